// File: doc/BRIEF.md
# Audio Serial Port Run/Stop and Flush Controller

This block sequences the start, stop and flush of a stereo serial audio port that has a transmit path and a receive path. Software writes per-direction start and stop commands and per-direction clear requests through a plain write port (valid, address, data). It also reads status back through a combinational read port. From these writes the block drives one shared run enable to both serializers, a DMA request enable for each direction, a one-cycle flush pulse for each direction and a busy flag.

The two paths always begin together: a start from either direction raises the shared transfer. The shared transfer falls only once both directions have asked to stop. A stop from one direction while the other is still running removes only that direction's DMA requests.

A clear must not cut the frame clock short. After the transfer stops, the block counts rising edges of the frame clock. A clear is applied only once `QUIET_EDGES` rising edges have been seen, which spans at least one whole frame period. A clear written earlier is kept pending and carried out when that interval ends. The frame-clock input is expected to be already synchronous to `clk`.

There is no data stream at this block's edge. The write port has no ready: every write is accepted in the cycle its valid is high, so there is no back-pressure. Reads are combinational and have no side effects.

Top module: `audio_xfer_ctrl`

## Requirements
- R1: A write to the command register (address 0) with a start bit set raises both `tx_run_en` and `rx_run_en` on the next clock edge. Start bits: bit 0 starts transmit, bit 2 starts receive.
- R2: Each direction's DMA enable (`tx_dma_en`, `rx_dma_en`) is set by that direction's start bit and cleared by its stop bit (bit 1 for transmit, bit 3 for receive). When both bits of one direction are set in the same write, the start wins.
- R3: The run enables fall only on a write that leaves neither direction's DMA enable set. A stop of one direction while the other still runs clears only that direction's DMA enable.
- R4: After the run enables fall, no flush pulse occurs until `QUIET_EDGES` (default 2) rising edges of `fs_clk` have been sampled. With `QUIET_EDGES` at 2, that spans at least one full frame period.
- R5: Read address 1 returns transmit clear status in bit 0 and receive clear status in bit 1. A status bit reads 1 from the edge that accepts the clear write until its flush pulse ends, and 0 afterwards. Once the quiet interval has elapsed, the flush pulse follows the clear write by one cycle, and the bit reads 0 two cycles after the write.
- R6: A clear written to address 1 (bit 0 transmit, bit 1 receive) while the transfer runs, or before the quiet interval ends, is held and never dropped. It is carried out once the transfer is stopped and the interval has elapsed.
- R7: Each accepted clear produces exactly one flush pulse of one cycle on its direction's flush output. A flush pulse never coincides with a raised run enable.
- R8: `busy` is 1 while the transfer runs, a clear is pending or a flush pulse is active, and 0 otherwise.
- R9: Read address 0 returns transmit DMA enable in bit 0, receive DMA enable in bit 1 and the shared run state in bit 2. Other read addresses return 0. Writes to other addresses change nothing.
- R10: After reset, all outputs are 0, nothing is pending and the quiet interval counts as already elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe, accepted in the same cycle |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| fs_clk | input | 1 | Frame clock, synchronous to clk |
| tx_run_en | output | 1 | Transmit serializer run enable |
| rx_run_en | output | 1 | Receive serializer run enable |
| tx_dma_en | output | 1 | Transmit DMA request enable |
| rx_dma_en | output | 1 | Receive DMA request enable |
| tx_flush | output | 1 | One-cycle transmit FIFO and counter reset |
| rx_flush | output | 1 | One-cycle receive FIFO and counter reset |
| busy | output | 1 | Transfer running or clear outstanding |

## Verification
Start and stop commands are applied in three orders, and each order separates shared run control from per-direction DMA control:
- transmit first, then receive, with transmit stopped first;
- both directions in a single write;
- a start and a stop of the same direction in one write.

Clears are applied in three situations, each exercising a different path:
- while running, so the clear must be held;
- after a stop, so the clear must wait for frame-clock edges;
- with the frame clock frozen, so no edge ever arrives until it resumes.

A lockstep behavioural model compares every output and the read data on every cycle. Separate checks measure the delay from stop to flush in frame periods.

// File: rtl/axc_pkg.sv
package axc_pkg;
  localparam int unsigned DIRS   = 2;
  localparam int unsigned DIR_TX = 0;
  localparam int unsigned DIR_RX = 1;
  localparam int unsigned CMD_BITS_PER_DIR = 2;

  localparam int unsigned REG_CMD   = 0;
  localparam int unsigned REG_CLEAR = 1;

  typedef struct packed {
    logic go;
    logic halt;
  } dir_cmd_t;

  function automatic dir_cmd_t pick_cmd(input logic [DIRS*CMD_BITS_PER_DIR-1:0] f,
                                        input int unsigned d);
    dir_cmd_t c;
    c.go   = f[d*CMD_BITS_PER_DIR];
    c.halt = f[d*CMD_BITS_PER_DIR+1];
    return c;
  endfunction
endpackage

// File: rtl/axc_run_seq.sv
module axc_run_seq
  import axc_pkg::*;
#(
  parameter int unsigned N_DIR = DIRS
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cmd_wr,
  input  logic [N_DIR*CMD_BITS_PER_DIR-1:0]   cmd_field,
  output logic [N_DIR-1:0]                    dma_en,
  output logic                                xfer,
  output logic                                go_any
);
  logic [N_DIR-1:0] run_q, run_d, go_vec;
  logic             xfer_q;

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    dir_cmd_t c;
    assign c = pick_cmd(cmd_field, d);
    assign go_vec[d] = cmd_wr & c.go;
    always_comb begin
      run_d[d] = run_q[d];
      if (cmd_wr && c.go)        run_d[d] = 1'b1;
      else if (cmd_wr && c.halt) run_d[d] = 1'b0;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) run_q[d] <= 1'b0;
      else        run_q[d] <= run_d[d];
    end

    // R3
    dma_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      run_q[d] |-> xfer_q);
  end

  assign go_any = |go_vec;

  always_ff @(posedge clk) begin
    if (!rst_n) xfer_q <= 1'b0;
    else        xfer_q <= go_any | (xfer_q & (|run_d));
  end

  assign dma_en = run_q;
  assign xfer   = xfer_q;

  // R1
  start_raises_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_any |=> xfer_q);
endmodule

// File: rtl/axc_quiet.sv
module axc_quiet #(
  parameter int unsigned QUIET_EDGES = 2,
  localparam int unsigned CNT_W = $clog2(QUIET_EDGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fs_clk,
  input  logic xfer,
  output logic done
);
  logic             fs_q, rise, done_q;
  logic [CNT_W-1:0] cnt_q;

  assign rise = fs_clk & ~fs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fs_q   <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b1;
    end else begin
      fs_q <= fs_clk;
      if (xfer) begin
        cnt_q  <= '0;
        done_q <= 1'b0;
      end else if (!done_q && rise) begin
        cnt_q <= cnt_q + 1'b1;
        if (cnt_q == CNT_W'(QUIET_EDGES - 1)) done_q <= 1'b1;
      end
    end
  end

  assign done = done_q;

  // R4
  quiet_ends_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> ($past(rise) && !$past(xfer)));
endmodule

// File: rtl/axc_clear_dir.sv
module axc_clear_dir (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic allow,
  output logic pend,
  output logic flush
);
  logic pend_q, flush_q, fire;

  assign fire = pend_q & allow;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= 1'b0;
      flush_q <= 1'b0;
    end else begin
      pend_q  <= (pend_q & ~allow) | req;
      flush_q <= fire;
    end
  end

  assign pend  = pend_q;
  assign flush = flush_q;

  // R6
  flush_from_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> $past(pend_q));
endmodule

// File: rtl/audio_xfer_ctrl.sv
module audio_xfer_ctrl
  import axc_pkg::*;
#(
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned QUIET_EDGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic              fs_clk,
  output logic              tx_run_en,
  output logic              rx_run_en,
  output logic              tx_dma_en,
  output logic              rx_dma_en,
  output logic              tx_flush,
  output logic              rx_flush,
  output logic              busy
);
  localparam int unsigned CMD_W = DIRS * CMD_BITS_PER_DIR;

  logic            cmd_wr, clr_wr, xfer, go_any, quiet_done, allow;
  logic [DIRS-1:0] dma_en, pend, flush;

  assign cmd_wr = wr_valid && (wr_addr == ADDR_W'(REG_CMD));
  assign clr_wr = wr_valid && (wr_addr == ADDR_W'(REG_CLEAR));

  axc_run_seq #(.N_DIR(DIRS)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr),
    .cmd_field(wr_data[CMD_W-1:0]),
    .dma_en(dma_en), .xfer(xfer), .go_any(go_any)
  );

  axc_quiet #(.QUIET_EDGES(QUIET_EDGES)) u_quiet (
    .clk(clk), .rst_n(rst_n), .fs_clk(fs_clk), .xfer(xfer), .done(quiet_done)
  );

  assign allow = ~xfer & quiet_done & ~go_any;

  for (genvar d = 0; d < DIRS; d++) begin : g_clr
    axc_clear_dir u_clr (
      .clk(clk), .rst_n(rst_n),
      .req(clr_wr & wr_data[d]),
      .allow(allow),
      .pend(pend[d]), .flush(flush[d])
    );
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ADDR_W'(REG_CMD)) begin
      rd_data[DIRS-1:0] = dma_en;
      rd_data[DIRS]     = xfer;
    end else if (rd_addr == ADDR_W'(REG_CLEAR)) begin
      rd_data[DIRS-1:0] = pend | flush;
    end
  end

  assign tx_run_en = xfer;
  assign rx_run_en = xfer;
  assign tx_dma_en = dma_en[DIR_TX];
  assign rx_dma_en = dma_en[DIR_RX];
  assign tx_flush  = flush[DIR_TX];
  assign rx_flush  = flush[DIR_RX];
  assign busy      = xfer | (|pend) | (|flush);

  // R7
  tx_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flush |-> !tx_run_en);
  // R7
  rx_flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flush |-> !rx_run_en);
  // R8
  busy_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend[DIR_TX]) |-> busy);
endmodule

// File: tb/audio_xfer_ctrl_tb_top.sv
module audio_xfer_ctrl_tb_top;
  localparam int AW = 4, DW = 32, QE = 2, FS_HALF = 8;

  logic clk = 0, rst_n = 0, wr_valid = 0, fs_clk = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0, rd_data;
  logic tx_run_en, rx_run_en, tx_dma_en, rx_dma_en, tx_flush, rx_flush, busy;

  always #10 clk = ~clk;

  audio_xfer_ctrl #(.ADDR_W(AW), .DATA_W(DW), .QUIET_EDGES(QE)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .fs_clk(fs_clk),
    .tx_run_en(tx_run_en), .rx_run_en(rx_run_en), .tx_dma_en(tx_dma_en),
    .rx_dma_en(rx_dma_en), .tx_flush(tx_flush), .rx_flush(rx_flush), .busy(busy)
  );

  int checks = 0, failures = 0, cyc = 0;
  int tx_fl_cnt = 0, rx_fl_cnt = 0, first_fl_cyc = -1;
  bit fs_run = 1, done_flag = 0;

  // behavioural reference
  bit m_tx, m_rx, m_xfer, m_fs_prev, m_qdone;
  int m_qcnt;
  bit m_pend[2], m_fl[2];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  function automatic int m_rd(input int a);
    if (a == 0) return {m_xfer, m_rx, m_tx};
    if (a == 1) return {(m_pend[1] | m_fl[1]), (m_pend[0] | m_fl[0])};
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tx = 0; m_rx = 0; m_xfer = 0; m_fs_prev = 0; m_qdone = 1; m_qcnt = 0;
      m_pend = '{0, 0}; m_fl = '{0, 0};
    end else begin
      bit go_t, go_r, cw, lw, rise, allow, ntx, nrx;
      cw = wr_valid && wr_addr == 0;
      lw = wr_valid && wr_addr == 1;
      go_t = cw && wr_data[0];
      go_r = cw && wr_data[2];
      rise = fs_clk && !m_fs_prev;
      allow = !m_xfer && m_qdone && !(go_t || go_r);
      for (int d = 0; d < 2; d++) begin
        m_fl[d] = m_pend[d] && allow;
        m_pend[d] = (m_pend[d] && !allow) || (lw && wr_data[d]);
      end
      if (m_xfer) begin m_qcnt = 0; m_qdone = 0; end
      else if (!m_qdone && rise) begin
        m_qcnt++;
        if (m_qcnt >= QE) m_qdone = 1;
      end
      ntx = go_t ? 1 : (cw && wr_data[1]) ? 0 : m_tx;
      nrx = go_r ? 1 : (cw && wr_data[3]) ? 0 : m_rx;
      m_xfer = go_t || go_r || (m_xfer && (ntx || nrx));
      m_tx = ntx; m_rx = nrx;
      m_fs_prev = fs_clk;
    end
  end

  // lockstep compare on every clock
  always @(posedge clk) begin
    #2;
    cyc++;
    if (tx_flush) begin tx_fl_cnt++; if (first_fl_cyc < 0) first_fl_cyc = cyc; end
    if (rx_flush) rx_fl_cnt++;
    if (rst_n && !done_flag) begin
      check(tx_run_en == m_xfer && rx_run_en == m_xfer, "R1/R3 run enables",
            {tx_run_en, rx_run_en}, {m_xfer, m_xfer});
      check(tx_dma_en == m_tx && rx_dma_en == m_rx, "R2 dma enables",
            {tx_dma_en, rx_dma_en}, {m_tx, m_rx});
      check(tx_flush == m_fl[0] && rx_flush == m_fl[1], "R4/R6/R7 flush",
            {tx_flush, rx_flush}, {m_fl[0], m_fl[1]});
      check(busy == (m_xfer | m_pend[0] | m_pend[1] | m_fl[0] | m_fl[1]), "R8 busy",
            busy, m_xfer | m_pend[0] | m_pend[1] | m_fl[0] | m_fl[1]);
      check(rd_data == DW'(m_rd(int'(rd_addr))), "R5/R9 read data", rd_data, m_rd(int'(rd_addr)));
    end
    if (cyc == 100000) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected=0", cyc);
      summary();
    end
  end

  initial begin
    int cnt = 0;
    forever begin
      @(negedge clk);
      if (fs_run) begin
        cnt++;
        if (cnt == FS_HALF) begin cnt = 0; fs_clk = ~fs_clk; end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_valid = 1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_valid = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic rd_chk(input int a, input int exp, input string req);
    rd_addr = AW'(a);
    #1;
    check(rd_data == DW'(exp), req, rd_data, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int stop_cyc, base_tx, base_rx;
    idle(3);
    rst_n = 1;
    idle(1);
    // R10 reset state
    check({tx_run_en, rx_run_en, tx_dma_en, rx_dma_en, tx_flush, rx_flush, busy} == 0,
          "R10 outputs after reset", busy, 0);
    rd_chk(1, 0, "R10 no clear pending");

    // R1 / R2 transmit start raises both run enables
    wr(0, 32'h1);
    check(tx_run_en && rx_run_en, "R1 start together", {tx_run_en, rx_run_en}, 3);
    rd_chk(0, 5, "R2 tx dma only");
    wr(0, 32'h4);
    rd_chk(0, 7, "R2 rx dma added");
    // R3 one direction stops, the other keeps running
    wr(0, 32'h2);
    rd_chk(0, 6, "R3 tx stop keeps run");

    // R6 clear while running is held
    wr(1, 32'h3);
    idle(40);
    rd_chk(1, 3, "R6 clear held while running");
    check(tx_fl_cnt == 0 && rx_fl_cnt == 0, "R6 no flush while running", tx_fl_cnt, 0);

    // R3 / R4 last stop drops the run, flush waits one frame period
    wr(0, 32'h8);
    stop_cyc = cyc;
    check(!tx_run_en && !rx_run_en, "R3 stop when both stopped", tx_run_en, 0);
    idle(60);
    check(first_fl_cyc - stop_cyc >= 2 * FS_HALF, "R4 quiet interval before flush",
          first_fl_cyc - stop_cyc, 2 * FS_HALF);
    check(first_fl_cyc - stop_cyc <= 4 * FS_HALF + 2, "R6 held clear executed",
          first_fl_cyc - stop_cyc, 4 * FS_HALF);
    check(tx_fl_cnt == 1 && rx_fl_cnt == 1, "R7 one pulse per clear", tx_fl_cnt, 1);
    rd_chk(1, 0, "R5 clear done");
    check(!busy, "R8 idle", busy, 0);

    // R5 clear after quiet interval completes within two cycles
    base_rx = rx_fl_cnt;
    wr(1, 32'h2);
    rd_chk(1, 2, "R5 clear reads one");
    idle(1);
    check(rx_flush == 1, "R5 flush one cycle after write", rx_flush, 1);
    rd_chk(1, 2, "R5 reads one during flush");
    idle(1);
    rd_chk(1, 0, "R5 reads zero after flush");
    check(rx_fl_cnt == base_rx + 1, "R7 single rx pulse", rx_fl_cnt, base_rx + 1);

    // R9 writes elsewhere ignored, other read addresses zero
    wr(5, 32'hF);
    rd_chk(0, 0, "R9 stray write ignored");
    rd_chk(5, 0, "R9 unmapped read");
    check(!busy, "R9 no clear from stray write", busy, 0);

    // R2 start and stop in one write: start wins; both start together
    wr(0, 32'h3);
    rd_chk(0, 5, "R2 start wins over stop");
    wr(0, 32'h4);
    wr(0, 32'hA);
    rd_chk(0, 0, "R3 both stopped in one write");

    // R6 frozen frame clock holds the clear
    fs_run = 0;
    base_tx = tx_fl_cnt;
    wr(1, 32'h1);
    idle(80);
    check(tx_fl_cnt == base_tx, "R4 no flush without frame edges", tx_fl_cnt, base_tx);
    rd_chk(1, 1, "R6 pending while frame clock frozen");
    check(busy, "R8 busy while pending", busy, 1);
    fs_run = 1;
    idle(80);
    check(tx_fl_cnt == base_tx + 1, "R6 executed after frame clock resumes", tx_fl_cnt, base_tx + 1);
    rd_chk(1, 0, "R5 cleared after resume");
    rd_addr = '0;
    idle(4);
    done_flag = 1;
    summary();
  end
endmodule